// File: doc/BRIEF.md
# Segmented physical address generator

This block forms 20-bit physical byte addresses from a 16-bit segment base and a 16-bit offset. It holds four segment bases: code, data, stack and extra. A requester presents an access class and an offset. The block selects the base that belongs to that class and computes base × 16 + offset, modulo 2^20. A registered byte strobe then carries the result to the memory side.

A word access is split into two byte cycles at consecutive physical addresses. The low-order byte goes out first, at the lower address. The high-order byte follows in the next cycle together with a completion pulse. While the high byte is pending, the block reports busy and ignores new requests. A write port loads any segment base. A load takes effect for requests accepted from the following cycle onward.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment base is FFFFh and the data, stack and extra bases are 0000h. While reset is held, strobe_o, byte_hi_o, done_o and busy_o are low and addr_o is zero.
- R2: A request that is accepted (req_valid_i high while busy_o is low) at a rising edge produces strobe_o high after that edge, with addr_o = base × 16 + offset.
- R3: req_class_i selects the base as follows: 0 is instruction fetch and uses the code base, 1 is data and uses the data base, 2 is stack and uses the stack base, 3 is string destination and uses the extra base.
- R4: A carry out of bit 19 of the sum is discarded, so the address wraps modulo 2^20 (for example FFFFh:0010h gives 00000h).
- R5: A byte access (req_word_i low) gives exactly one strobe cycle, with byte_hi_o low and done_o high in that cycle.
- R6: A word access gives two strobe cycles back to back. The first has byte_hi_o low at address A. The second has byte_hi_o high at address (A + 1) mod 2^20.
- R7: busy_o is high exactly during the first byte cycle of a word access. A request presented while busy_o is high is ignored and produces no strobe.
- R8: The write port loads seg_wdata_i into the base chosen by seg_sel_i (0 code, 1 data, 2 stack, 3 extra) at a rising edge where seg_we_i is high. A request accepted at that same edge still uses the old base.
- R9: done_o is high only in the last byte cycle of an access, and never without strobe_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment base write enable |
| seg_sel_i | input | 2 | Segment base to write |
| seg_wdata_i | input | 16 | New segment base value |
| req_valid_i | input | 1 | Access request |
| req_class_i | input | 2 | Access class selecting the base |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_offset_i | input | 16 | Offset within the segment |
| busy_o | output | 1 | High byte pending, requests ignored |
| strobe_o | output | 1 | Byte cycle valid |
| addr_o | output | 20 | Physical byte address |
| byte_hi_o | output | 1 | Current cycle carries the high-order byte |
| done_o | output | 1 | Last byte cycle of the access |

## Verification
The assertions check the timing of the byte cycles on every cycle. A high byte always follows a low byte at the next address, and busy always leads into a high byte. done only appears together with a strobe, and a low-byte strobe appears only after an accepted request. Only the bench scenarios can show the arithmetic itself: that each class picks the right base, that the sum wraps at 2^20, that the reset values of the bases are correct, and that a base load is ordered correctly against a request in the same cycle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    CLS_FETCH  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_STACK  = 2'd2,
    CLS_STRDST = 2'd3
  } acc_class_e;

  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned SEL_W   = 2;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W      = 16,
  parameter logic [15:0] CODE_RESET = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [SEG_W-1:0] rdata_o
);
  logic [SEG_W-1:0] base_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (g == 0) ? SEG_W'(CODE_RESET) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             base_q[g] <= RST_VAL;
      else if (we_i && (wsel_i == SEL_W'(g)))  base_q[g] <= wdata_i;
    end
  end

  assign rdata_o = base_q[rsel_i];
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  // carry out of the top bit is dropped: modulo 2^ADDR_W
  assign phys_o = {base_i, SHIFT'(0)} + ADDR_W'(off_i);
endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] phys_i,
  output logic              busy_o,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              byte_hi_o,
  output logic              done_o
);
  logic              pend_q, strobe_q, hi_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fire;

  assign fire = req_valid_i && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      strobe_q <= 1'b0;
      hi_q     <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
    end else if (fire) begin
      pend_q   <= req_word_i;
      strobe_q <= 1'b1;
      hi_q     <= 1'b0;
      done_q   <= !req_word_i;
      addr_q   <= phys_i;
    end else if (pend_q) begin
      pend_q   <= 1'b0;
      strobe_q <= 1'b1;
      hi_q     <= 1'b1;
      done_q   <= 1'b1;
      addr_q   <= addr_q + ADDR_W'(1);
    end else begin
      strobe_q <= 1'b0;
      hi_q     <= 1'b0;
      done_q   <= 1'b0;
    end
  end

  assign busy_o    = pend_q;
  assign strobe_o  = strobe_q;
  assign addr_o    = addr_q;
  assign byte_hi_o = hi_q;
  assign done_o    = done_q;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W      = 16,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned SHIFT      = 4,
  parameter logic [15:0] CODE_RESET = 16'hFFFF,
  localparam int unsigned ADDR_W    = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_we_i,
  input  logic [1:0]        seg_sel_i,
  input  logic [SEG_W-1:0]  seg_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_class_i,
  input  logic              req_word_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  output logic              busy_o,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              byte_hi_o,
  output logic              done_o
);
  logic [SEG_W-1:0]  base;
  logic [ADDR_W-1:0] phys;
  logic [SEL_W-1:0]  rsel;

  // class codes line up with segment indices: fetch/code, data, stack, strdst/extra
  always_comb begin
    unique case (acc_class_e'(req_class_i))
      CLS_FETCH:  rsel = 2'd0;
      CLS_DATA:   rsel = 2'd1;
      CLS_STACK:  rsel = 2'd2;
      default:    rsel = 2'd3;
    endcase
  end

  seg_bank #(.SEG_W(SEG_W), .CODE_RESET(CODE_RESET)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_sel_i),
    .wdata_i (seg_wdata_i),
    .rsel_i  (rsel),
    .rdata_o (base)
  );

  seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) i_add (
    .base_i (base),
    .off_i  (req_offset_i),
    .phys_o (phys)
  );

  byte_sequencer #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_word_i  (req_word_i),
    .phys_i      (phys),
    .busy_o      (busy_o),
    .strobe_o    (strobe_o),
    .addr_o      (addr_o),
    .byte_hi_o   (byte_hi_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              strobe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              byte_hi_o,
  input logic              done_o
);
  assert_hi_follows_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && byte_hi_o) |-> ($past(strobe_o) && !$past(byte_hi_o)
                                 && addr_o == $past(addr_o) + ADDR_W'(1)));

  assert_busy_then_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (strobe_o && byte_hi_o));

  assert_done_with_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> strobe_o);

  assert_hi_is_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && byte_hi_o) |-> done_o);

  assert_lo_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !byte_hi_o) |-> $past(req_valid_i && !busy_o));

  assert_byte_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !byte_hi_o && done_o) |-> !busy_o);
endmodule

bind seg_addr_gen seg_addr_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .strobe_o    (strobe_o),
  .addr_o      (addr_o),
  .byte_hi_o   (byte_hi_o),
  .done_o      (done_o)
);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_sel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic        req_word = 1'b0;
  logic [15:0] req_offset = '0;
  logic        busy, strobe, byte_hi, done;
  logic [19:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_we_i(seg_we), .seg_sel_i(seg_sel), .seg_wdata_i(seg_wdata),
    .req_valid_i(req_valid), .req_class_i(req_class), .req_word_i(req_word),
    .req_offset_i(req_offset),
    .busy_o(busy), .strobe_o(strobe), .addr_o(addr), .byte_hi_o(byte_hi), .done_o(done)
  );

  // class(2) offset(16) expected(20); bases CS=2500 DS=7FA2 SS=3500 ES=24F6
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 16'h95F3, 20'h2E5F3},
    {2'd1, 16'h438E, 20'h83DAE},
    {2'd2, 16'hFFFE, 20'h44FFE},
    {2'd3, 16'h634A, 20'h2B2AA},
    {2'd1, 16'h0000, 20'h7FA20},
    {2'd1, 16'hFFFF, 20'h8FA1F},
    {2'd2, 16'h0000, 20'h35000},
    {2'd0, 16'h0000, 20'h25000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sample the five outputs as one word: {strobe,hi,done,busy,addr}
  function automatic logic [23:0] outs();
    return {strobe, byte_hi, done, busy, addr};
  endfunction

  task automatic load_seg(logic [1:0] s, logic [15:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_sel = s; seg_wdata = v;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  // drive a request at a negedge; returns sampled outputs at the next negedge
  task automatic issue(logic [1:0] c, logic w, logic [15:0] o, output logic [23:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_class = c; req_word = w; req_offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    r = outs();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] r;
    #12;
    // R1: outputs quiet in reset
    check("R1 reset outputs", 32'(outs()), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R4: code base FFFF after reset, fetch 0010 wraps to 00000
    issue(2'd0, 1'b0, 16'h0000, r);
    check("R1 code reset base", 32'(r[19:0]), 32'hFFFF0);
    issue(2'd1, 1'b0, 16'h0000, r);
    check("R1 data reset base", 32'(r), 32'({4'b1010, 20'h00000}));
    issue(2'd0, 1'b0, 16'h0010, r);
    check("R4 wrap at 2^20", 32'(r[19:0]), 32'h00000);

    // R6/R4: word whose second byte wraps: FFFF:000F -> FFFFF then 00000
    issue(2'd0, 1'b1, 16'h000F, r);
    check("R6 word lo byte", 32'(r), 32'({4'b1001, 20'hFFFFF}));
    @(negedge clk); r = outs();
    check("R6 word hi byte wraps", 32'(r), 32'({4'b1110, 20'h00000}));

    // R8: load bases
    load_seg(2'd0, 16'h2500);
    load_seg(2'd1, 16'h7FA2);
    load_seg(2'd2, 16'h3500);
    load_seg(2'd3, 16'h24F6);

    // R2/R3/R5: table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][37:36], 1'b0, VEC[i][35:20], r);
      check($sformatf("R2 R3 R5 vector %0d", i), 32'(r),
            32'({4'b1010, VEC[i][19:0]}));
    end

    // R6: stack word 3500:FFFE
    issue(2'd2, 1'b1, 16'hFFFE, r);
    check("R6 stack word lo", 32'(r), 32'({4'b1001, 20'h44FFE}));
    @(negedge clk); r = outs();
    check("R6 stack word hi", 32'(r), 32'({4'b1110, 20'h44FFF}));
    @(negedge clk); r = outs();
    check("R9 idle after word", 32'(r[23:20]), 32'h0);

    // R7: request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_class = 2'd1; req_word = 1'b1; req_offset = 16'h0100;
    @(negedge clk);
    check("R7 busy on lo byte", 32'(busy), 32'h1);
    req_word = 1'b0; req_offset = 16'h1234;   // stays valid, should be dropped
    @(negedge clk);
    req_valid = 1'b0;
    r = outs();
    check("R7 hi byte unaffected", 32'(r), 32'({4'b1110, 20'h7FB21}));
    @(negedge clk); r = outs();
    check("R7 ignored request gave no strobe", 32'(r[23:20]), 32'h0);

    // R8: same-edge write uses old base, next request new base
    @(negedge clk);
    seg_we = 1'b1; seg_sel = 2'd1; seg_wdata = 16'h1000;
    req_valid = 1'b1; req_class = 2'd1; req_word = 1'b0; req_offset = 16'h0000;
    @(negedge clk);
    seg_we = 1'b0; req_valid = 1'b0;
    check("R8 same edge old base", 32'(addr), 32'h7FA20);
    issue(2'd1, 1'b0, 16'h0000, r);
    check("R8 new base", 32'(r[19:0]), 32'h10000);

    // R8: write to extra does not disturb stack
    load_seg(2'd3, 16'hABCD);
    issue(2'd2, 1'b0, 16'h0001, r);
    check("R8 other base kept", 32'(r[19:0]), 32'h35001);
    issue(2'd3, 1'b0, 16'h0001, r);
    check("R3 R8 extra base", 32'(r[19:0]), 32'hABCD1);

    // R1: async reset restores bases
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 reset mid-run", 32'(outs()), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    issue(2'd3, 1'b0, 16'h0001, r);
    check("R1 extra reset base", 32'(r[19:0]), 32'h00001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule